// File: doc/BRIEF.md
# Transfer-Information DMA Sequencer

This block runs the data-moving command of a SCSI host adapter. When the command strobe arrives, it takes the byte count that software wrote into the two counter bytes and clips that count to the bytes still owed in the current bus phase. It then feeds a memory-side DMA engine one request per device chunk. Each request is no larger than what the device has buffered and no larger than what remains of the transfer. It keeps a signed phase balance that shrinks toward zero as bytes move. A positive balance means device-to-host traffic and a negative balance means host-to-device traffic.

A transfer can finish in two ways. It finishes at once when a request leaves part of a device chunk unused, or when a read has used up its count while the device still owes data. In every other case the finish waits until the device announces its next chunk. At the finish the block posts a fixed completion status: interrupt pending, terminal count set, interrupt code 0x10, and the visible counter cleared. It also pulses an interrupt line, which also tells neighbouring logic to clear its sequence-step and FIFO-flag registers. When a command byte sequence is pending, the same strobe instead issues a single command fetch of at most 32 bytes.

Top module: `xfer_dma_ctrl`

## Requirements
- R1: The requested length is the counter high byte (select 1) times 256 plus the low byte (select 0), as written before the strobe; a combined value of zero means 65536 bytes.
- R2: With `cmd_phase_i` low, the transfer length is the smaller of R1's length and the magnitude of the phase balance. With it high, one command request (`dma_cmd_o` and `dma_to_dev_o` high) of at most 32 bytes appears in the cycle after the strobe, and no data transfer starts.
- R3: `stat_tc_o` clears in the cycle after a strobe or a counter-byte write. A completion in the same cycle as a counter write wins, though the written byte is still stored for the next strobe. The strobe copies the stored count to `cnt_o`.
- R4: Each data request moves the smaller of the remaining length and the unused device chunk. With no chunk held, no request is made.
- R5: After each request the phase balance moves toward zero by the request length: it rises when the balance was negative at the strobe (host-to-device, `dma_to_dev_o` high) and falls otherwise.
- R6: A request that leaves part of the device chunk unused completes the transfer.
- R7: A device-to-host request that uses up both the chunk and the remaining length, and leaves a positive balance, completes at once. Otherwise a transfer with no length left completes when the device announces its next chunk, provided the balance is zero or negative.
- R8: Completion raises `irq_o` for one cycle, one cycle later. In that same cycle `stat_int_o` and `stat_tc_o` are high, `intr_code_o` is 0x10 and `cnt_o` is zero.
- R9: A strobe that arrives while a transfer is active drops it. A data strobe restarts the length calculation, and a command strobe leaves no data transfer running.
- R10: `int_ack_i` clears `stat_int_o` in the next cycle, unless a completion happens in the same cycle.
- R11: After reset every status output, `cnt_o`, `phase_o` and every request output are zero.
- R12: `dev_next_o` pulses in the request cycle whenever a request uses up the whole device chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_wr_i | input | 1 | Counter byte write strobe |
| cnt_sel_i | input | CNT_W/8 index | Byte select: 0 low, 1 high |
| cnt_data_i | input | 8 | Counter byte value |
| ti_cmd_i | input | 1 | Transfer-information command strobe |
| cmd_phase_i | input | 1 | A command byte sequence is pending |
| phase_ld_i | input | 1 | Load the phase balance |
| phase_i | input | PHASE_W | Signed phase balance to load |
| chunk_vld_i | input | 1 | Device announces a new chunk |
| chunk_len_i | input | CNT_W+1 | Bytes in the announced chunk |
| int_ack_i | input | 1 | Interrupt register read, clears pending |
| dma_req_o | output | 1 | DMA request this cycle |
| dma_len_o | output | CNT_W+1 | Bytes for this request, zero when idle |
| dma_to_dev_o | output | 1 | Request reads memory toward the device |
| dma_cmd_o | output | 1 | Request fetches command bytes |
| dev_next_o | output | 1 | Device chunk used up, ask for more |
| phase_o | output | PHASE_W | Signed phase balance |
| cnt_o | output | CNT_W | Visible transfer counter |
| stat_tc_o | output | 1 | Terminal count status |
| stat_int_o | output | 1 | Interrupt pending status |
| intr_code_o | output | 8 | Interrupt cause code |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
A finish and a software write to the counter bytes can fall in the same cycle. So can a finish and an interrupt acknowledge. The bench sets this up by announcing a chunk together with the strobe, so that the request, and with it a partial-chunk finish, lands in the very next cycle. It then drives the counter write and the acknowledge into that same cycle. The behavioural model expects terminal count and interrupt pending to stay set and the counter to read zero, and a later strobe must show the byte that was written in the colliding cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam logic [7:0] DONE_CODE = 8'h10;
  localparam int         CMD_MAX   = 32;
endpackage

// File: rtl/xfer_len_calc.sv
module xfer_len_calc #(
  parameter int CNT_W   = 16,
  parameter int PHASE_W = 24,
  parameter int CMD_MAX = 32
) (
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic signed [PHASE_W-1:0] phase_i,
  input  logic                      cmd_i,
  output logic [CNT_W:0]            len_o
);
  localparam int LEN_W = CNT_W + 1;
  localparam int MAG_W = (PHASE_W > LEN_W) ? PHASE_W : LEN_W;

  logic [LEN_W-1:0]   full_len;
  logic [PHASE_W-1:0] abs_phase;
  logic [MAG_W-1:0]   full_ext, cap;

  always_comb begin
    // zero count encodes the largest transfer
    full_len  = (cnt_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_i};
    abs_phase = phase_i[PHASE_W-1] ? (~phase_i + 1'b1) : phase_i;
    full_ext  = MAG_W'(full_len);
    cap       = cmd_i ? MAG_W'(CMD_MAX) : MAG_W'(abs_phase);
    len_o     = LEN_W'((full_ext < cap) ? full_ext : cap);
  end

  always_comb begin
    p_cmd_cap_r2: assert (!cmd_i || int'(len_o) <= CMD_MAX);
  end
endmodule

// File: rtl/xfer_stepper.sv
module xfer_stepper #(
  parameter int CNT_W   = 16,
  parameter int PHASE_W = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      cmd_start_i,
  input  logic [CNT_W:0]            len_i,
  input  logic                      phase_ld_i,
  input  logic signed [PHASE_W-1:0] phase_i,
  input  logic                      chunk_vld_i,
  input  logic [CNT_W:0]            chunk_len_i,
  output logic                      dma_req_o,
  output logic [CNT_W:0]            dma_len_o,
  output logic                      dma_to_dev_o,
  output logic                      dma_cmd_o,
  output logic                      dev_next_o,
  output logic                      done_o,
  output logic signed [PHASE_W-1:0] phase_o
);
  localparam int LEN_W = CNT_W + 1;

  logic                      run_q, dir_q, cmd_q;
  logic [LEN_W-1:0]          left_q, avail_q, cmd_len_q, step_n;
  logic signed [PHASE_W-1:0] phase_q, phase_nx, n_ext;
  logic                      any_start, step, drained, last_read, late_done;

  always_comb begin
    any_start = start_i | cmd_start_i;
    step      = run_q & ~any_start & (left_q != '0) & (avail_q != '0);
    step_n    = (left_q < avail_q) ? left_q : avail_q;
    n_ext     = signed'(PHASE_W'(step_n));
    phase_nx  = dir_q ? (phase_q + n_ext) : (phase_q - n_ext);
    drained   = step & (step_n == avail_q);
    // read ran out of length while the device still owes bytes
    last_read = drained & ~dir_q & (step_n == left_q) & (phase_nx > 0);
    // deferred finish: next chunk announcement closes a spent transfer
    late_done = run_q & ~any_start & (left_q == '0) & chunk_vld_i & (phase_q <= 0);
    done_o    = (step & ~drained) | last_read | late_done;
  end

  assign dma_req_o    = step | cmd_q;
  assign dma_cmd_o    = cmd_q;
  assign dma_len_o    = cmd_q ? cmd_len_q : (step ? step_n : '0);
  assign dma_to_dev_o = cmd_q | (step & dir_q);
  assign dev_next_o   = drained;
  assign phase_o      = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      dir_q     <= 1'b0;
      cmd_q     <= 1'b0;
      left_q    <= '0;
      avail_q   <= '0;
      cmd_len_q <= '0;
      phase_q   <= '0;
    end else begin
      cmd_q <= cmd_start_i;
      if (cmd_start_i) cmd_len_q <= len_i;

      if (any_start) begin
        run_q  <= start_i;
        left_q <= len_i;
        dir_q  <= phase_q[PHASE_W-1];
      end else begin
        if (done_o) run_q <= 1'b0;
        if (step) left_q <= left_q - step_n;
      end

      if (chunk_vld_i) avail_q <= chunk_len_i;
      else if (step)   avail_q <= avail_q - step_n;

      if (phase_ld_i) phase_q <= phase_i;
      else if (step)  phase_q <= phase_nx;
    end
  end

  p_left_monotone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !any_start) |=> (left_q <= $past(left_q)));

  p_done_stops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !run_q);

  p_read_falls_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !phase_ld_i && !dir_q) |=> (phase_q < $signed($past(phase_q))));

  p_write_rises_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !phase_ld_i && dir_q) |=> (phase_q > $signed($past(phase_q))));
endmodule

// File: rtl/xfer_status.sv
module xfer_status #(
  parameter int CNT_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cnt_wr_i,
  input  logic [$clog2(CNT_W/8)-1:0]    cnt_sel_i,
  input  logic [7:0]                    cnt_data_i,
  input  logic                          ti_cmd_i,
  input  logic                          done_i,
  input  logic                          int_ack_i,
  output logic [CNT_W-1:0]              reload_o,
  output logic [CNT_W-1:0]              cnt_o,
  output logic                          tc_o,
  output logic                          int_o,
  output logic [7:0]                    intr_o,
  output logic                          irq_o
);
  import xfer_pkg::*;
  localparam int NB    = CNT_W / 8;
  localparam int SEL_W = $clog2(NB);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       byte_q <= '0;
      else if (cnt_wr_i && cnt_sel_i == SEL_W'(b))        byte_q <= cnt_data_i;
    end
    assign reload_o[b*8 +: 8] = byte_q;
  end

  logic [CNT_W-1:0] cnt_q;
  logic             tc_q, int_q, irq_q;
  logic [7:0]       intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tc_q   <= 1'b0;
      int_q  <= 1'b0;
      intr_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= done_i;
      if (done_i) begin
        tc_q   <= 1'b1;
        int_q  <= 1'b1;
        intr_q <= DONE_CODE;
        cnt_q  <= '0;
      end else begin
        if (ti_cmd_i) begin
          tc_q  <= 1'b0;
          cnt_q <= reload_o;
        end else if (cnt_wr_i) begin
          tc_q <= 1'b0;
        end
        if (int_ack_i) int_q <= 1'b0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign tc_o   = tc_q;
  assign int_o  = int_q;
  assign intr_o = intr_q;
  assign irq_o  = irq_q;

  p_done_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (tc_q && int_q && cnt_q == '0 && intr_q == DONE_CODE));

  p_ti_clears_tc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ti_cmd_i && !done_i) |=> !tc_q);

  p_wr_clears_tc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr_i && !done_i) |=> !tc_q);

  p_ack_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_ack_i && !done_i) |=> !int_q);
endmodule

// File: rtl/xfer_dma_ctrl.sv
module xfer_dma_ctrl #(
  parameter int CNT_W   = 16,
  parameter int PHASE_W = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cnt_wr_i,
  input  logic [$clog2(CNT_W/8)-1:0] cnt_sel_i,
  input  logic [7:0]                 cnt_data_i,
  input  logic                       ti_cmd_i,
  input  logic                       cmd_phase_i,
  input  logic                       phase_ld_i,
  input  logic signed [PHASE_W-1:0]  phase_i,
  input  logic                       chunk_vld_i,
  input  logic [CNT_W:0]             chunk_len_i,
  input  logic                       int_ack_i,
  output logic                       dma_req_o,
  output logic [CNT_W:0]             dma_len_o,
  output logic                       dma_to_dev_o,
  output logic                       dma_cmd_o,
  output logic                       dev_next_o,
  output logic signed [PHASE_W-1:0]  phase_o,
  output logic [CNT_W-1:0]           cnt_o,
  output logic                       stat_tc_o,
  output logic                       stat_int_o,
  output logic [7:0]                 intr_code_o,
  output logic                       irq_o
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W:0]   xfer_len;
  logic             done;
  logic             data_start, cmd_start;

  assign data_start = ti_cmd_i & ~cmd_phase_i;
  assign cmd_start  = ti_cmd_i &  cmd_phase_i;

  xfer_len_calc #(.CNT_W(CNT_W), .PHASE_W(PHASE_W), .CMD_MAX(xfer_pkg::CMD_MAX)) u_len (
    .cnt_i   (reload),
    .phase_i (phase_o),
    .cmd_i   (cmd_phase_i),
    .len_o   (xfer_len)
  );

  xfer_stepper #(.CNT_W(CNT_W), .PHASE_W(PHASE_W)) u_step (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (data_start),
    .cmd_start_i  (cmd_start),
    .len_i        (xfer_len),
    .phase_ld_i   (phase_ld_i),
    .phase_i      (phase_i),
    .chunk_vld_i  (chunk_vld_i),
    .chunk_len_i  (chunk_len_i),
    .dma_req_o    (dma_req_o),
    .dma_len_o    (dma_len_o),
    .dma_to_dev_o (dma_to_dev_o),
    .dma_cmd_o    (dma_cmd_o),
    .dev_next_o   (dev_next_o),
    .done_o       (done),
    .phase_o      (phase_o)
  );

  xfer_status #(.CNT_W(CNT_W)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_wr_i   (cnt_wr_i),
    .cnt_sel_i  (cnt_sel_i),
    .cnt_data_i (cnt_data_i),
    .ti_cmd_i   (ti_cmd_i),
    .done_i     (done),
    .int_ack_i  (int_ack_i),
    .reload_o   (reload),
    .cnt_o      (cnt_o),
    .tc_o       (stat_tc_o),
    .int_o      (stat_int_o),
    .intr_o     (intr_code_o),
    .irq_o      (irq_o)
  );
endmodule

// File: tb/tb_xfer_dma_ctrl.sv
module tb_xfer_dma_ctrl;
  localparam int CNT_W   = 16;
  localparam int PHASE_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                      cnt_wr = 0, cnt_sel = 0, ti = 0, cmd_phase = 0;
  logic                      phase_ld = 0, chunk_vld = 0, int_ack = 0;
  logic [7:0]                cnt_data = 0;
  logic signed [PHASE_W-1:0] phase_in = 0;
  logic [CNT_W:0]            chunk_len = 0;
  logic                      dma_req, dma_to_dev, dma_cmd, dev_next, tc, intp, irq;
  logic [CNT_W:0]            dma_len;
  logic signed [PHASE_W-1:0] phase_out;
  logic [CNT_W-1:0]          cnt_out;
  logic [7:0]                intr_code;

  xfer_dma_ctrl #(.CNT_W(CNT_W), .PHASE_W(PHASE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_wr_i(cnt_wr), .cnt_sel_i(cnt_sel),
    .cnt_data_i(cnt_data), .ti_cmd_i(ti), .cmd_phase_i(cmd_phase),
    .phase_ld_i(phase_ld), .phase_i(phase_in), .chunk_vld_i(chunk_vld),
    .chunk_len_i(chunk_len), .int_ack_i(int_ack), .dma_req_o(dma_req),
    .dma_len_o(dma_len), .dma_to_dev_o(dma_to_dev), .dma_cmd_o(dma_cmd),
    .dev_next_o(dev_next), .phase_o(phase_out), .cnt_o(cnt_out),
    .stat_tc_o(tc), .stat_int_o(intp), .intr_code_o(intr_code), .irq_o(irq)
  );

  int total = 0, bad = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_lo, m_hi, m_cnt, m_tc, m_int, m_intr, m_irq;
  int m_run, m_left, m_avail, m_phase, m_dir, m_cmd, m_cmdlen;

  function automatic int want_len();
    int full, cap;
    full = m_hi * 256 + m_lo;
    if (full == 0) full = 65536;
    cap = cmd_phase ? 32 : (m_phase < 0 ? -m_phase : m_phase);
    return (full < cap) ? full : cap;
  endfunction

  task automatic predict(output int st, output int n, output int drn, output int dn,
                         output int np);
    st  = (m_run != 0 && !ti && m_left != 0 && m_avail != 0) ? 1 : 0;
    n   = (m_left < m_avail) ? m_left : m_avail;
    np  = m_dir ? m_phase + n : m_phase - n;
    drn = (st != 0 && n == m_avail) ? 1 : 0;
    dn  = 0;
    if (st != 0 && drn == 0) dn = 1;
    if (drn != 0 && m_dir == 0 && n == m_left && np > 0) dn = 1;
    if (m_run != 0 && !ti && m_left == 0 && chunk_vld && m_phase <= 0) dn = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_cnt = 0; m_tc = 0; m_int = 0; m_intr = 0; m_irq = 0;
      m_run = 0; m_left = 0; m_avail = 0; m_phase = 0; m_dir = 0; m_cmd = 0; m_cmdlen = 0;
    end else begin
      int st, n, drn, dn, np, ln;
      predict(st, n, drn, dn, np);
      ln = want_len();
      m_irq = dn;
      if (dn != 0) begin
        m_tc = 1; m_int = 1; m_intr = 16; m_cnt = 0;
      end else begin
        if (ti) begin m_tc = 0; m_cnt = m_hi * 256 + m_lo; end
        else if (cnt_wr) m_tc = 0;
        if (int_ack) m_int = 0;
      end
      if (cnt_wr) begin
        if (cnt_sel) m_hi = cnt_data; else m_lo = cnt_data;
      end
      m_cmd = (ti && cmd_phase) ? 1 : 0;
      if (m_cmd != 0) m_cmdlen = ln;
      if (ti) begin
        m_run = cmd_phase ? 0 : 1; m_left = ln; m_dir = (m_phase < 0) ? 1 : 0;
      end else begin
        if (dn != 0) m_run = 0;
        if (st != 0) m_left = m_left - n;
      end
      if (chunk_vld) m_avail = chunk_len;
      else if (st != 0) m_avail = m_avail - n;
      if (phase_ld) m_phase = phase_in;
      else if (st != 0) m_phase = np;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      int st, n, drn, dn, np;
      predict(st, n, drn, dn, np);
      chk("R4 model dma_req", dma_req, (st != 0 || m_cmd != 0) ? 1 : 0);
      chk("R4 model dma_len", dma_len, m_cmd != 0 ? m_cmdlen : (st != 0 ? n : 0));
      chk("R2 model dma_cmd", dma_cmd, m_cmd);
      chk("R5 model dma_to_dev", dma_to_dev, (m_cmd != 0 || (st != 0 && m_dir != 0)) ? 1 : 0);
      chk("R12 model dev_next", dev_next, drn);
      chk("R8 model irq", irq, m_irq);
      chk("R3 model tc", tc, m_tc);
      chk("R10 model int", intp, m_int);
      chk("R8 model intr_code", intr_code, m_intr);
      chk("R8 model cnt", cnt_out, m_cnt);
      chk("R5 model phase", phase_out, m_phase);
    end
  end

  task automatic nx();
    @(negedge clk);
    ti = 0; cnt_wr = 0; phase_ld = 0; chunk_vld = 0; int_ack = 0;
  endtask

  task automatic set_cnt(int v);
    nx(); cnt_wr = 1; cnt_sel = 0; cnt_data = 8'(v);
    nx(); cnt_wr = 1; cnt_sel = 1; cnt_data = 8'(v >> 8);
  endtask

  task automatic set_phase(int v);
    nx(); phase_ld = 1; phase_in = PHASE_W'(v);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=below limit", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R11 reset cnt", cnt_out, 0);
    chk("R11 reset tc", tc, 0);
    chk("R11 reset int", intp, 0);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset intr_code", intr_code, 0);
    chk("R11 reset dma_req", dma_req, 0);
    chk("R11 reset phase", phase_out, 0);
    @(negedge clk); rst_n = 1;

    // read, length clipped by counter, chunked, immediate finish
    set_cnt(16); set_phase(100);
    nx(); ti = 1;
    nx(); chunk_vld = 1; chunk_len = 8;
    #5 chk("R3 strobe copies count", cnt_out, 16);
    chk("R3 strobe clears tc", tc, 0);
    nx(); #5;
    chk("R4 first request length", dma_len, 8);
    chk("R12 chunk used up", dev_next, 1);
    nx(); nx(); #5 chk("R4 waits without chunk", dma_req, 0);
    nx(); chunk_vld = 1; chunk_len = 8;
    nx(); #5 chk("R4 second request", dma_len, 8);
    nx(); #5;
    chk("R7 read exhausted finishes at once", irq, 1);
    chk("R8 interrupt code", intr_code, 16);
    chk("R8 counter cleared", cnt_out, 0);
    chk("R8 tc set", tc, 1);
    chk("R5 phase fell", phase_out, 84);

    // zero count means 65536
    nx(); int_ack = 1;
    nx(); #5 chk("R10 ack clears pending", intp, 0);
    set_cnt(0); set_phase(70000);
    nx(); ti = 1; chunk_vld = 1; chunk_len = 65536;
    nx(); #5 chk("R1 zero count full length", dma_len, 65536);
    nx(); #5 chk("R7 read finish with balance left", irq, 1);

    // partial chunk
    set_cnt(40); set_phase(50);
    nx(); ti = 1; chunk_vld = 1; chunk_len = 100;
    nx(); #5;
    chk("R4 length limited by count", dma_len, 40);
    chk("R12 no pulse on partial use", dev_next, 0);
    nx(); #5 chk("R6 partial chunk finishes", irq, 1);

    // host-to-device, deferred finish
    set_cnt(32); set_phase(-12);
    nx(); ti = 1; chunk_vld = 1; chunk_len = 5;
    nx(); #5;
    chk("R5 direction toward device", dma_to_dev, 1);
    chk("R2 length clipped by balance", dma_len, 5);
    nx(); chunk_vld = 1; chunk_len = 7;
    nx(); #5 chk("R2 remainder", dma_len, 7);
    nx(); nx(); #5 chk("R7 write deferred", irq, 0);
    chk("R5 balance reached zero", phase_out, 0);
    nx(); chunk_vld = 1; chunk_len = 4;
    nx(); #5 chk("R7 next chunk closes write", irq, 1);

    // read with zero balance left: deferred
    set_cnt(10); set_phase(10);
    nx(); ti = 1; chunk_vld = 1; chunk_len = 10;
    nx(); nx(); nx(); #5 chk("R7 read deferred", irq, 0);
    nx(); chunk_vld = 1; chunk_len = 3;
    nx(); #5 chk("R7 read closed by chunk", irq, 1);

    // command fetch
    set_cnt(100);
    nx(); ti = 1; cmd_phase = 1;
    nx(); #5;
    chk("R2 command request", dma_cmd, 1);
    chk("R2 command capped", dma_len, 32);
    set_cnt(5);
    nx(); ti = 1;
    nx(); #5 chk("R2 short command", dma_len, 5);
    cmd_phase = 0;

    // restart
    set_cnt(40); set_phase(50);
    nx(); ti = 1;
    set_cnt(3);
    nx(); ti = 1; chunk_vld = 1; chunk_len = 10;
    nx(); #5 chk("R9 restart new length", dma_len, 3);
    nx(); #5 chk("R9 restart finish", irq, 1);
    set_cnt(40);
    nx(); ti = 1;
    nx(); ti = 1; cmd_phase = 1;
    nx(); cmd_phase = 0; chunk_vld = 1; chunk_len = 10;
    nx(); #5 chk("R9 command strobe dropped data", dma_req, 0);

    // collision: finish with counter write and acknowledge
    set_cnt(4); set_phase(20);
    nx(); ti = 1; chunk_vld = 1; chunk_len = 9;
    nx(); cnt_wr = 1; cnt_sel = 0; cnt_data = 7; int_ack = 1;
    nx(); #5;
    chk("R3 finish beats write", tc, 1);
    chk("R10 finish beats ack", intp, 1);
    chk("R8 counter zero", cnt_out, 0);
    nx(); ti = 1;
    nx(); #5 chk("R3 written byte kept", cnt_out, 7);

    repeat (4) nx();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule